// File: doc/BRIEF.md
# Sequential Radix-4 Booth Multiplier

This block forms the signed product of two 10-bit two's-complement operands over several clock cycles. A pulse on the start input while the block is idle captures both operands. The block then retires two multiplier bits per cycle by radix-4 Booth recoding. Each cycle adds zero, plus or minus the multiplicand, or plus or minus twice the multiplicand into the upper half of a running accumulator, and then shifts the accumulator right by two places with sign fill.

After the last step a one-cycle completion pulse marks the 20-bit product as valid. The product then holds until the next accepted start. A request that arrives while a multiply is running is dropped without effect.

Top module: `booth_mul`

## Requirements
- R1: After a synchronous active-high reset, busy is 0, done is 0 and product is all zeros.
- R2: A start seen high at a clock edge while busy is 0 captures both operands at that edge. Busy is then 1 for exactly 5 consecutive cycles.
- R3: Done is 1 for exactly one cycle, the cycle right after the last busy cycle, and busy is 0 in that cycle. Done and busy are never 1 together.
- R4: While done is 1, product equals the signed product of the captured operands as a 20-bit two's-complement value. While busy is 0, product holds that value until the next accepted start.
- R5: Multiplicand 0011011110 and multiplier 0001110010 give product 00000110001011011100.
- R6: Operands at the extremes of the signed range give exact results, including negative partial products: -512 x -512 = 262144, -512 x 511, 511 x 511, -1 x -1, and either operand zero.
- R7: Step i takes its digit from multiplier bits (2i+1, 2i, 2i-1), with a 0 below bit 0. The triples map as follows: 000 and 111 give 0; 001 and 010 give +1; 011 gives +2; 100 gives -2; 101 and 110 give -1. Alternating and mixed bit patterns in the multiplier therefore give exact products.
- R8: A start, or any change of the operand inputs, while busy is 1 has no effect. The running multiply keeps its timing and its result.
- R9: With start held high continuously, a new multiply is accepted in each cycle where done is 1. Back-to-back operations then repeat every 6 cycles, and each one gives a correct result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a multiply; accepted only when idle |
| multiplicand | input | 10 | Signed multiplicand, sampled on an accepted start |
| multiplier | input | 10 | Signed multiplier, sampled on an accepted start |
| busy | output | 1 | High during the 5 iteration cycles |
| done | output | 1 | One-cycle pulse when the product is valid |
| product | output | 20 | Signed product; valid from done until the next accepted start |

## Verification
A corrupted step counter or control state shows up on the busy and done pins. It appears in the first cycle where it differs, because the bench model predicts both pins on every clock. A wrong recoded digit, a lost sign bit in the shift, or a stale lower bit passed between steps changes the result. That error is seen in the done cycle of the same multiply, five cycles after the start is accepted. Operand patterns are chosen so that every digit value, including both negative multiples, is hit in the upper and lower steps.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;   // capture operands, clear accumulator
    logic step;   // one radix-4 iteration
  } dpCtrl_t;

  // Recoded digit of one multiplier bit pair
  typedef enum logic [2:0] {
    DIG_ZERO = 3'd0,
    DIG_POS1 = 3'd1,
    DIG_POS2 = 3'd2,
    DIG_NEG1 = 3'd3,
    DIG_NEG2 = 3'd4
  } boothDigit_t;

  // Triple order: {upper bit, lower bit, bit below the pair}
  function automatic boothDigit_t decodeTriple(input logic [2:0] triple);
    boothDigit_t d;
    case (triple)
      3'b001, 3'b010: d = DIG_POS1;
      3'b011:         d = DIG_POS2;
      3'b100:         d = DIG_NEG2;
      3'b101, 3'b110: d = DIG_NEG1;
      default:        d = DIG_ZERO;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_mul_pkg::*;
#(
  parameter int OP_W = 10
) (
  input  logic [2:0]             triple,
  input  logic [OP_W-1:0]        mcand,
  output logic signed [OP_W+1:0] partial
);

  localparam int PP_W = OP_W + 2;

  boothDigit_t       digit;
  logic signed [PP_W-1:0] mOne;
  logic signed [PP_W-1:0] mTwo;

  assign digit = decodeTriple(triple);
  assign mOne  = {{2{mcand[OP_W-1]}}, mcand};
  assign mTwo  = {mOne[PP_W-2:0], 1'b0};

  always_comb begin
    case (digit)
      DIG_POS1: partial = mOne;
      DIG_POS2: partial = mTwo;
      DIG_NEG1: partial = -mOne;
      DIG_NEG2: partial = -mTwo;
      default:  partial = '0;
    endcase
  end

endmodule

// File: rtl/booth_dp.sv
module booth_dp
  import booth_mul_pkg::*;
#(
  parameter int OP_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtrl_t           ctl,
  input  logic [OP_W-1:0]   mcandIn,
  input  logic [OP_W-1:0]   mplierIn,
  output logic [2*OP_W-1:0] product
);

  localparam int HI_W   = OP_W + 2;
  localparam int WIDE_W = HI_W + OP_W;

  logic [OP_W-1:0]          mcandReg;
  logic signed [HI_W-1:0]   hiReg;
  logic [OP_W-1:0]          loReg;
  logic                     prevBit;

  logic signed [HI_W-1:0]   partial;
  logic signed [HI_W-1:0]   sum;
  logic signed [WIDE_W-1:0] wide;
  logic signed [WIDE_W-1:0] shifted;

  booth_recode #(.OP_W(OP_W)) u_recode (
    .triple  ({loReg[1], loReg[0], prevBit}),
    .mcand   (mcandReg),
    .partial (partial)
  );

  assign sum     = hiReg + partial;
  assign wide    = {sum, loReg};
  assign shifted = wide >>> 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      mcandReg <= '0;
      hiReg    <= '0;
      loReg    <= '0;
      prevBit  <= 1'b0;
    end else if (ctl.load) begin
      mcandReg <= mcandIn;
      hiReg    <= '0;
      loReg    <= mplierIn;
      prevBit  <= 1'b0;
    end else if (ctl.step) begin
      hiReg    <= shifted[WIDE_W-1:OP_W];
      loReg    <= shifted[OP_W-1:0];
      prevBit  <= loReg[1];
    end
  end

  assign product = {hiReg[OP_W-1:0], loReg};

  // R4: result is held while no strobe is active
  a_r4_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!ctl.load && !ctl.step) |=> $stable(product));

  // R2: an accepted start clears the upper half and captures the multiplier
  a_r2_load_clears: assert property (@(posedge clk) disable iff (rst)
    ctl.load |=> (hiReg == '0 && loReg == $past(mplierIn) && !prevBit));

  // R8: the multiplicand cannot change during iterations
  a_r8_mcand_frozen: assert property (@(posedge clk) disable iff (rst)
    ctl.step |=> $stable(mcandReg));

endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
  import booth_mul_pkg::*;
#(
  parameter int STEPS = 5
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  output logic    busy,
  output logic    done,
  output dpCtrl_t ctl
);

  localparam int CNT_W = $clog2(STEPS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

  typedef enum logic {S_IDLE, S_RUN} ctrlState_t;

  ctrlState_t      state;
  logic [CNT_W-1:0] stepCnt;

  assign busy     = (state == S_RUN);
  assign ctl.load = (state == S_IDLE) && start;
  assign ctl.step = (state == S_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            state   <= S_RUN;
            stepCnt <= '0;
          end
        end
        default: begin
          if (stepCnt == LAST) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else begin
            stepCnt <= stepCnt + 1'b1;
          end
        end
      endcase
    end
  end

  // R2: an accepted start enters the first iteration
  a_r2_start_enters: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (busy && stepCnt == '0));

  // R8: a running multiply advances one step per cycle regardless of start
  a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
    (busy && stepCnt != LAST) |=> (busy && stepCnt == $past(stepCnt) + 1'b1));

  // R3: the last step is followed by the completion pulse
  a_r3_done_follows: assert property (@(posedge clk) disable iff (rst)
    (busy && stepCnt == LAST) |=> (done && !busy));

  // R3: done lasts one cycle
  a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3: done and busy are exclusive
  a_r3_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(done && busy));

endmodule

// File: rtl/booth_mul.sv
module booth_mul
  import booth_mul_pkg::*;
#(
  parameter int OP_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [OP_W-1:0]   multiplicand,
  input  logic [OP_W-1:0]   multiplier,
  output logic              busy,
  output logic              done,
  output logic [2*OP_W-1:0] product
);

  localparam int STEPS = OP_W / 2;

  dpCtrl_t ctl;

  booth_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (busy),
    .done  (done),
    .ctl   (ctl)
  );

  booth_dp #(.OP_W(OP_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .mcandIn  (multiplicand),
    .mplierIn (multiplier),
    .product  (product)
  );

endmodule

// File: tb/booth_mul_bench.sv
module booth_mul_bench;

  localparam int W  = 10;
  localparam int PW = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [W-1:0]  mc = '0;
  logic [W-1:0]  mp = '0;
  logic          busy;
  logic          done;
  logic [PW-1:0] product;

  always #10 clk = ~clk;   // 50 MHz

  booth_mul u_booth_mul (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .multiplicand (mc),
    .multiplier   (mp),
    .busy         (busy),
    .done         (done),
    .product      (product)
  );

  int    nRun = 0;
  int    nFail = 0;
  bit    finished = 0;
  string curReq = "R1";

  // Behavioural reference: remaining cycles, pending operands, held result
  int            refCnt = 0;
  bit            refDone = 0;
  logic [PW-1:0] refProd = '0;
  int            capA = 0;
  int            capB = 0;

  always @(posedge clk) begin
    if (rst) begin
      refCnt  = 0;
      refDone = 0;
      refProd = '0;
    end else begin
      refDone = 0;
      if (refCnt > 0) begin
        refCnt--;
        if (refCnt == 0) begin
          refDone = 1;
          refProd = PW'(capA * capB);
        end
      end else if (start) begin
        capA   = int'($signed(mc));
        capB   = int'($signed(mp));
        refCnt = 5;
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [PW-1:0] act, input logic [PW-1:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Compared every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R2", "busy", PW'(busy), PW'(refCnt > 0));
      chk("R3", "done", PW'(done), PW'(refDone));
      if (refCnt == 0) chk(curReq, "product", product, refProd);
    end
  end

  task automatic runMul(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    @(negedge clk);
    mc    = a;
    mp    = b;
    start = 1'b1;
    @(negedge clk);
    start  = 1'b0;
    curReq = req;
    repeat (6) @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state observed for several cycles
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R5: worked example
    runMul(10'b0011011110, 10'b0001110010, "R5");

    // R6: range extremes and zero operands
    runMul(10'h200, 10'h200, "R6");
    runMul(10'h200, 10'h1FF, "R6");
    runMul(10'h1FF, 10'h200, "R6");
    runMul(10'h1FF, 10'h1FF, "R6");
    runMul(10'h3FF, 10'h3FF, "R6");
    runMul(10'h000, 10'h2B7, "R6");
    runMul(10'h1C3, 10'h000, "R6");

    // R7: multiplier patterns exercising every recoded digit
    runMul(10'h1DE, 10'b1010101010, "R7");
    runMul(10'h25B, 10'b0101010101, "R7");
    runMul(10'h0F1, 10'b0110110110, "R7");
    runMul(10'h30A, 10'b1001100110, "R7");
    runMul(10'h200, 10'b1100110011, "R7");

    // R4: general operands
    for (int i = 0; i < 40; i++) begin
      runMul(W'($urandom), W'($urandom), "R4");
    end

    // R8: start and operand changes while busy are ignored
    @(negedge clk);
    mc = 10'h155; mp = 10'h2A9; start = 1'b1;
    @(negedge clk);
    curReq = "R8";
    mc = 10'h3C0; mp = 10'h07F;
    repeat (3) @(negedge clk);
    mc = 10'h001; mp = 10'h3FE;
    @(negedge clk);
    start = 1'b0;
    repeat (8) @(negedge clk);

    // R9: start held high; new multiply accepted in each done cycle
    curReq = "R9";
    mc = 10'h0A7; mp = 10'h36C; start = 1'b1;
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      if (k % 5 == 2) begin
        mc = W'($urandom);
        mp = W'($urandom);
      end
    end
    start = 1'b0;
    repeat (8) @(negedge clk);

    finished = 1;
    summary();
    $finish;
  end

endmodule